// File: doc/BRIEF.md
# Receive FIFO Frame Drop Filter

This block stands between the byte stream of an Ethernet receive MAC and the write side of a receive FIFO. Every accepted byte is written to the FIFO memory at a private write pointer, and the block alone decides when those bytes become visible to the reader. It shows them by moving a published write pointer forward. A frame that must not reach the reader is discarded by rewinding the private pointer to the saved start of the frame. The reader sees none of its bytes.

The decision is taken on the last byte of a frame, where the MAC delivers the status bits. It depends on the frame length, the error class, and two forwarding controls: one for short good frames and one for errored frames. It also depends on whether the frame was already released. In threshold mode, a frame is released to the reader once enough of its bytes are stored. From then on, the published pointer follows the write pointer, and the frame can no longer be withdrawn. In store-and-forward mode, nothing of a frame is published before its last byte. Each committed frame produces a status word with its length and flags.

Top module: `rx_frame_filter`

## Requirements
- R1: After reset, `pub_ptr` is 0, `mem_we` is low and `stat_valid` is low.
- R2: A byte is accepted when `in_valid` is high and either `in_sof` is high or a frame is open. An accepted byte is written one cycle later on `mem_we`/`mem_addr`/`mem_wdata`, at consecutive addresses modulo DEPTH. A byte with `in_valid` high, no open frame and `in_sof` low is ignored.
- R3: A good frame (no flag set) of 64 or more bytes is committed. One cycle after its last byte, `pub_ptr` equals the address after that byte. In the same cycle, `stat_valid` pulses with `stat_len` (every received byte) and `stat_flags`, coded bit0 CRC, bit1 collision, bit2 watchdog, bit3 MAC overflow, bit4 truncated.
- R4: A good frame under 64 bytes is committed only when `cfg_fwd_small` is 1. Otherwise it is dropped: no status, `pub_ptr` is unchanged, and the next frame is written from the dropped frame's start address.
- R5: With `cfg_fwd_err` at 0, a frame with any of the CRC, collision, watchdog or overflow inputs set on its last byte is dropped.
- R6: With `cfg_fwd_err` at 1, errored frames are committed, except a runt (collision set and length under 64), which is dropped.
- R7: A byte that arrives while the FIFO holds DEPTH bytes (write pointer minus `rd_ptr`) is not stored, and no later byte of that frame is stored. An unreleased truncated frame is dropped whatever the forwarding controls say.
- R8: In threshold mode, when the stored count of a frame reaches `cfg_thresh` on a byte that is not its last, the frame is released. From the next cycle, `pub_ptr` follows every write. A released frame is always committed with its flags, including when it is short, errored or a runt. Reaching the threshold on the last byte does not release the frame.
- R9: In store-and-forward mode, `pub_ptr` does not move before the last byte of a frame.
- R10: A start marker while an unreleased frame is open abandons that frame. The new frame is written from the abandoned frame's start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thresh_mode | input | 1 | 1 selects threshold release, 0 store-and-forward |
| cfg_thresh | input | TW | Stored byte count that releases a frame |
| cfg_fwd_small | input | 1 | Forward good frames shorter than 64 bytes |
| cfg_fwd_err | input | 1 | Forward errored frames other than runts |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame, status valid |
| in_data | input | 8 | Frame byte |
| in_crc_err | input | 1 | CRC error (with last byte) |
| in_col | input | 1 | Collision seen (with last byte) |
| in_wdt | input | 1 | Receive watchdog expired (with last byte) |
| in_ovf | input | 1 | MAC overflow (with last byte) |
| rd_ptr | input | AW+1 | Reader pointer, with wrap bit |
| mem_we | output | 1 | FIFO memory write enable |
| mem_addr | output | AW | FIFO memory write address |
| mem_wdata | output | 8 | FIFO memory write data |
| pub_ptr | output | AW+1 | Published write pointer, with wrap bit |
| stat_valid | output | 1 | Status word strobe for a committed frame |
| stat_len | output | LW | Committed frame length in bytes |
| stat_flags | output | 5 | Committed frame flags |

## Verification
Memory writes are due one clock after the accepting byte. `pub_ptr` and the status word are due one clock after the last byte of a frame. In threshold mode, `pub_ptr` moves one clock after the byte that reaches the threshold. The bench drives inputs and compares every output on the falling clock edge, against a behavioural model that updates on the rising edge from the same inputs. Each comparison is therefore made against the value due after exactly one register stage.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int MIN_FRAME = 64;

    typedef struct packed {
        logic trunc;
        logic ovf;
        logic wdt;
        logic col;
        logic crc;
    } rxf_flags_t;
endpackage

// File: rtl/rxf_verdict.sv
module rxf_verdict
    import rxf_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic [LW-1:0] len,
    input  rxf_flags_t    flags,
    input  logic          released,
    input  logic          fwd_small,
    input  logic          fwd_err,
    output logic          keep
);
    logic short_frame;
    logic any_err;
    logic runt;
    logic drop;

    always_comb begin
        short_frame = len < LW'(MIN_FRAME);
        any_err     = flags.crc | flags.col | flags.wdt | flags.ovf;
        runt        = flags.col & short_frame;
        drop        = flags.trunc
                    | (any_err & (~fwd_err | runt))
                    | (~any_err & short_frame & ~fwd_small);
        keep        = released | ~drop;
    end
endmodule

// File: rtl/rxf_frame_ctl.sv
module rxf_frame_ctl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int LW    = 16,
    parameter int TW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_thresh_mode,
    input  logic [TW-1:0]   cfg_thresh,
    input  logic            cfg_fwd_small,
    input  logic            cfg_fwd_err,
    input  logic            in_valid,
    input  logic            in_sof,
    input  logic            in_eof,
    input  logic [7:0]      in_data,
    input  logic            in_crc_err,
    input  logic            in_col,
    input  logic            in_wdt,
    input  logic            in_ovf,
    input  logic [$clog2(DEPTH):0] rd_ptr,
    output logic            mem_we,
    output logic [$clog2(DEPTH)-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    output logic [$clog2(DEPTH):0] pub_ptr,
    output logic            stat_valid,
    output logic [LW-1:0]   stat_len,
    output rxf_flags_t      stat_flags
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic          active;
        logic          released;
        logic          trunc;
        logic [LW-1:0] len;
        logic [PW-1:0] wr;
        logic [PW-1:0] start;
        logic [PW-1:0] pub;
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    wdata;
        logic          sv;
        logic [LW-1:0] slen;
        rxf_flags_t    sflags;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic          take;
    logic          restart;
    logic [PW-1:0] cur_wr;
    logic [PW-1:0] occ;
    logic          full;
    logic          trunc_old;
    logic          rel_old;
    logic          store;
    logic [LW-1:0] len_new;
    rxf_flags_t    flags_new;
    logic          keep;

    assign take      = in_valid & (in_sof | st_q.active);
    assign restart   = in_sof & st_q.active & ~st_q.released;
    assign cur_wr    = restart ? st_q.start : st_q.wr;
    assign occ       = cur_wr - rd_ptr;
    assign full      = occ[AW];
    assign trunc_old = in_sof ? 1'b0 : st_q.trunc;
    assign rel_old   = in_sof ? 1'b0 : st_q.released;
    assign store     = ~trunc_old & ~full;
    assign len_new   = (in_sof ? '0 : st_q.len) + LW'(1);
    assign flags_new = '{trunc: trunc_old | full, ovf: in_ovf, wdt: in_wdt,
                         col: in_col, crc: in_crc_err};

    rxf_verdict #(.LW(LW)) u_verdict (
        .len       (len_new),
        .flags     (flags_new),
        .released  (rel_old),
        .fwd_small (cfg_fwd_small),
        .fwd_err   (cfg_fwd_err),
        .keep      (keep)
    );

    always_comb begin
        logic [PW-1:0] start_n;
        logic [PW-1:0] wr_after;
        logic [31:0]   stored;
        st_d    = st_q;
        st_d.we = 1'b0;
        st_d.sv = 1'b0;
        start_n  = in_sof ? cur_wr : st_q.start;
        wr_after = store ? cur_wr + PW'(1) : cur_wr;
        stored   = 32'(PW'(wr_after - start_n));
        if (take) begin
            st_d.start = start_n;
            st_d.len   = len_new;
            st_d.trunc = flags_new.trunc;
            st_d.wr    = wr_after;
            if (store) begin
                st_d.we    = 1'b1;
                st_d.addr  = cur_wr[AW-1:0];
                st_d.wdata = in_data;
            end
            if (in_eof) begin
                st_d.active   = 1'b0;
                st_d.released = 1'b0;
                if (keep) begin
                    st_d.pub    = wr_after;
                    st_d.sv     = 1'b1;
                    st_d.slen   = len_new;
                    st_d.sflags = flags_new;
                end else begin
                    st_d.wr = start_n;
                end
            end else begin
                st_d.active   = 1'b1;
                st_d.released = rel_old
                              | (cfg_thresh_mode & (stored >= 32'(cfg_thresh)));
                if (st_d.released) begin
                    st_d.pub = wr_after;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we     = st_q.we;
    assign mem_addr   = st_q.addr;
    assign mem_wdata  = st_q.wdata;
    assign pub_ptr    = st_q.pub;
    assign stat_valid = st_q.sv;
    assign stat_len   = st_q.slen;
    assign stat_flags = st_q.sflags;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(PW'(st_q.wr - rd_ptr)) <= DEPTH);

    // R9
    pub_le_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(PW'(st_q.wr - st_q.pub)) <= DEPTH);

    // R3
    stat_pub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (pub_ptr == st_q.wr));

    // R3
    stat_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(in_valid && in_eof));

    // R2
    pub_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(pub_ptr));
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int LW    = 16,
    parameter int TW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_thresh_mode,
    input  logic [TW-1:0]   cfg_thresh,
    input  logic            cfg_fwd_small,
    input  logic            cfg_fwd_err,
    input  logic            in_valid,
    input  logic            in_sof,
    input  logic            in_eof,
    input  logic [7:0]      in_data,
    input  logic            in_crc_err,
    input  logic            in_col,
    input  logic            in_wdt,
    input  logic            in_ovf,
    input  logic [AW:0]     rd_ptr,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [7:0]      mem_wdata,
    output logic [AW:0]     pub_ptr,
    output logic            stat_valid,
    output logic [LW-1:0]   stat_len,
    output logic [4:0]      stat_flags
);
    rxf_flags_t flags_w;

    rxf_frame_ctl #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_thresh_mode (cfg_thresh_mode),
        .cfg_thresh      (cfg_thresh),
        .cfg_fwd_small   (cfg_fwd_small),
        .cfg_fwd_err     (cfg_fwd_err),
        .in_valid        (in_valid),
        .in_sof          (in_sof),
        .in_eof          (in_eof),
        .in_data         (in_data),
        .in_crc_err      (in_crc_err),
        .in_col          (in_col),
        .in_wdt          (in_wdt),
        .in_ovf          (in_ovf),
        .rd_ptr          (rd_ptr),
        .mem_we          (mem_we),
        .mem_addr        (mem_addr),
        .mem_wdata       (mem_wdata),
        .pub_ptr         (pub_ptr),
        .stat_valid      (stat_valid),
        .stat_len        (stat_len),
        .stat_flags      (flags_w)
    );

    assign stat_flags = flags_w;
endmodule

// File: tb/rx_frame_filter_test.sv
module rx_frame_filter_test;
    localparam int DEPTH = 128;
    localparam int AW    = 7;
    localparam int LW    = 16;
    localparam int TW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_thresh_mode = 1'b0;
    logic [TW-1:0] cfg_thresh = '0;
    logic cfg_fwd_small = 1'b0;
    logic cfg_fwd_err = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = '0;
    logic in_crc_err = 1'b0, in_col = 1'b0, in_wdt = 1'b0, in_ovf = 1'b0;
    logic [AW:0] rd_ptr = '0;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [AW:0] pub_ptr;
    logic stat_valid;
    logic [LW-1:0] stat_len;
    logic [4:0] stat_flags;

    always #2.5 clk = ~clk;

    rx_frame_filter #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_thresh_mode(cfg_thresh_mode),
        .cfg_thresh(cfg_thresh), .cfg_fwd_small(cfg_fwd_small),
        .cfg_fwd_err(cfg_fwd_err), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .in_crc_err(in_crc_err),
        .in_col(in_col), .in_wdt(in_wdt), .in_ovf(in_ovf), .rd_ptr(rd_ptr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pub_ptr(pub_ptr), .stat_valid(stat_valid), .stat_len(stat_len),
        .stat_flags(stat_flags)
    );

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";
    logic [7:0] dbyte = 8'h10;

    // behavioural reference
    logic       m_act = 0, m_rel = 0, m_tr = 0;
    int         m_len = 0;
    logic [7:0] m_wr = 0, m_st = 0, m_pub = 0;
    logic       e_we = 0, e_sv = 0;
    logic [6:0] e_addr = 0;
    logic [7:0] e_data = 0;
    int         e_len = 0;
    logic [4:0] e_fl = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_rel = 0; m_tr = 0; m_len = 0;
            m_wr = 0; m_st = 0; m_pub = 0; e_we = 0; e_sv = 0;
        end else begin
            e_we = 0;
            e_sv = 0;
            if (in_valid && (in_sof || m_act)) begin
                logic [7:0] cw;
                logic err, shrt, keep;
                cw = (in_sof && m_act && !m_rel) ? m_st : m_wr;
                if (in_sof) begin
                    m_st = cw; m_len = 0; m_tr = 0; m_rel = 0;
                end
                m_len = m_len + 1;
                if (!m_tr && 8'(cw - rd_ptr) < 8'(DEPTH)) begin
                    e_we = 1; e_addr = cw[6:0]; e_data = in_data;
                    cw = cw + 8'd1;
                end else begin
                    m_tr = 1;
                end
                m_wr = cw;
                if (in_eof) begin
                    err  = in_crc_err | in_col | in_wdt | in_ovf;
                    shrt = m_len < 64;
                    if (m_rel)                          keep = 1;
                    else if (m_tr)                      keep = 0;
                    else if (err && !cfg_fwd_err)       keep = 0;
                    else if (err && in_col && shrt)     keep = 0;
                    else if (!err && shrt)              keep = cfg_fwd_small;
                    else                                keep = 1;
                    if (keep) begin
                        m_pub = m_wr; e_sv = 1; e_len = m_len;
                        e_fl = {m_tr, in_ovf, in_wdt, in_col, in_crc_err};
                    end else begin
                        m_wr = m_st;
                    end
                    m_act = 0; m_rel = 0;
                end else begin
                    m_act = 1;
                    if (cfg_thresh_mode && !m_rel && int'(8'(m_wr - m_st)) >= int'(cfg_thresh))
                        m_rel = 1;
                    if (m_rel) m_pub = m_wr;
                end
            end
        end
    end

    task automatic check_outputs();
        bit bad = 0;
        n_vec++;
        if (mem_we !== e_we || (e_we && (mem_addr !== e_addr || mem_wdata !== e_data))) begin
            bad = 1;
            $display("FAIL %s write: we=%0b addr=%0d data=%02h expected we=%0b addr=%0d data=%02h",
                     cur_req, mem_we, mem_addr, mem_wdata, e_we, e_addr, e_data);
        end
        if (pub_ptr !== m_pub) begin
            bad = 1;
            $display("FAIL %s pub_ptr=%0d expected %0d", cur_req, pub_ptr, m_pub);
        end
        if (stat_valid !== e_sv || (e_sv && (int'(stat_len) != e_len || stat_flags !== e_fl))) begin
            bad = 1;
            $display("FAIL %s status: v=%0b len=%0d fl=%05b expected v=%0b len=%0d fl=%05b",
                     cur_req, stat_valid, stat_len, stat_flags, e_sv, e_len, e_fl);
        end
        if (bad) n_bad++;
    endtask

    task automatic send(input bit v, input bit s, input bit e, input logic [3:0] errs);
        @(negedge clk);
        check_outputs();
        in_valid = v; in_sof = s; in_eof = e; in_data = dbyte;
        {in_ovf, in_wdt, in_col, in_crc_err} = e ? errs : 4'b0;
        if (v) dbyte = dbyte + 8'd7;
    endtask

    task automatic drain();
        send(0, 0, 0, 4'b0);
        rd_ptr = m_pub;
        send(0, 0, 0, 4'b0);
    endtask

    // n bytes, a one-cycle gap after byte gap_at (0 = none), end on last unless open
    task automatic frame(input int n, input logic [3:0] errs, input int gap_at, input bit open);
        for (int i = 1; i <= n; i++) begin
            send(1, i == 1, (i == n) && !open, errs);
            if (i == gap_at) send(0, 0, 0, 4'b0);
        end
        if (!open) drain();
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired (R1..)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            n_vec++;
            if (pub_ptr !== '0 || mem_we !== 1'b0 || stat_valid !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 reset: pub=%0d we=%0b sv=%0b expected 0 0 0",
                         pub_ptr, mem_we, stat_valid);
            end
        end
        rst_n = 1'b1;
        drain();

        cur_req = "R3";  frame(70, 4'b0000, 0, 0);           // good long
        cur_req = "R4";  frame(40, 4'b0000, 0, 0);           // short dropped
        cfg_fwd_small = 1;
        cur_req = "R4";  frame(40, 4'b0000, 0, 0);           // short kept
        cfg_fwd_small = 0;
        cur_req = "R5";  frame(80, 4'b0001, 0, 0);           // crc dropped
        cur_req = "R5";  frame(90, 4'b1000, 0, 0);           // mac overflow dropped
        cfg_fwd_err = 1;
        cur_req = "R6";  frame(30, 4'b0010, 0, 0);           // runt dropped
        cur_req = "R6";  frame(30, 4'b0001, 0, 0);           // short crc kept
        cur_req = "R6";  frame(100, 4'b0100, 0, 0);          // watchdog kept
        cur_req = "R6";  frame(64, 4'b0010, 0, 0);           // collision at 64 kept
        cfg_fwd_small = 1;
        cur_req = "R7";  frame(150, 4'b0000, 0, 0);          // truncated, dropped
        cur_req = "R7";  frame(70, 4'b0000, 0, 0);           // after rewind
        cfg_fwd_small = 0; cfg_fwd_err = 0;
        cfg_thresh_mode = 1; cfg_thresh = 8'd16;
        cur_req = "R8";  frame(30, 4'b0010, 0, 0);           // released runt kept
        cur_req = "R8";  frame(20, 4'b0000, 0, 0);           // released short kept
        cfg_thresh = 8'd30;
        cur_req = "R8";  frame(30, 4'b0000, 0, 0);           // threshold on last byte: dropped
        cfg_thresh = 8'd40;
        cur_req = "R8";  frame(150, 4'b0001, 0, 0);          // released then truncated: kept
        cfg_thresh_mode = 0;
        cur_req = "R9";  frame(70, 4'b0000, 20, 0);          // gap, no early publish
        cur_req = "R2";  send(1, 0, 0, 4'b0); send(1, 0, 1, 4'b0); drain();  // stray bytes
        cur_req = "R2";  frame(65, 4'b0000, 5, 0);
        cur_req = "R10"; frame(10, 4'b0000, 0, 1);           // abandoned
        cur_req = "R10"; frame(70, 4'b0000, 0, 0);
        cfg_thresh_mode = 1; cfg_thresh = 8'd4;
        cur_req = "R10"; frame(10, 4'b0000, 0, 1);           // released, not rewound
        cfg_thresh_mode = 0;
        cur_req = "R10"; frame(66, 4'b0000, 0, 0);
        repeat (4) drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule